// File: doc/BRIEF.md
# Sv32 Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table in memory. A requester raises a request carrying the virtual address, the access kind (instruction fetch, data load or data store), the current privilege mode, a flag that skips the user/supervisor page check, a translation-enable bit and the physical page number of the root table. The request stays stable until the walker pulses its completion strobe.

The walker reads page-table entries one word at a time through a read port with an acknowledge and an error flag. It sorts each entry into pointer, leaf or invalid, handles 4 MiB megapages found at the top level, checks the page number range, the access permission and the privilege, and stores the entry back with its accessed/dirty bits set when that changes it. The answer is either a physical address or a fault code together with the faulting virtual address.

Top module: `sv32_walker`

## Requirements
- R1: The top-level entry is read at address root_ppn*4096 + VA[31:22]*4; a pointer found there leads to a second read at PTE[29:10]*4096 + VA[21:12]*4. Every read address is word aligned.
- R2: The low four PTE bits, taken as X(bit 3), W(bit 2), R(bit 1), V(bit 0), decode as: 0001 is a pointer; 0011, 0111, 1001, 1011 and 1111 are leaves; every other code is invalid and gives a page fault. A pointer found at the second level also gives a page fault.
- R3: A leaf at the top level maps a 4 MiB page: if PTE[19:10] is nonzero the walk gives a page fault, otherwise the final page number is PTE[29:20] followed by VA[21:12].
- R4: A leaf with PTE bit 30 or 31 set gives a page fault; a top-level pointer with either bit set gives an access fault without a second read.
- R5: A fetch needs X (bit 3), a load needs R (bit 1), a store needs W (bit 2); a missing bit gives a page fault. Access codes: 0 fetch, 1 load, 2 store.
- R6: Unless the bypass flag is set, the U bit (bit 4) must equal the user-mode input (1 user, 0 supervisor); a mismatch gives a page fault.
- R7: A successful fetch or load ORs the A bit (bit 6) into the leaf, a store ORs A and D (bit 7); the result is written to the leaf's address once, only when it differs from the read value. No write follows a fault.
- R8: A read returning the error flag gives an access fault (code 2); page faults use code 1, success code 0. On any fault the faulting virtual address is reported.
- R9: On success the physical address is the final page number followed by VA[11:0]; with translation disabled the address passes through unchanged and no read is made.
- R10: The completion strobe lasts one cycle, at most two reads occur per walk, a pending read keeps its request and address until acknowledged, and a read and a write never occur in the same cycle.
- R11: After reset the block is idle: no read, no write, no completion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request, held until done |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_umode | input | 1 | 1 user mode, 0 supervisor mode |
| req_bypass | input | 1 | Skip the U-bit privilege check |
| req_xlate_en | input | 1 | Translation enabled |
| req_root_ppn | input | 20 | Page number of the top-level table |
| mem_rd_req | output | 1 | Page-table read request |
| mem_rd_addr | output | 32 | Read word address (byte units) |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Page-table entry read |
| mem_rd_err | input | 1 | Read failed, with ack |
| mem_wr_en | output | 1 | Single-cycle entry write-back |
| mem_wr_addr | output | 32 | Write-back address |
| mem_wr_data | output | 32 | Updated entry |
| done | output | 1 | One-cycle completion strobe |
| rsp_paddr | output | 32 | Physical address on success |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 access fault |
| rsp_fault_vaddr | output | 32 | Faulting virtual address |

## Verification
A wrong walk state shows up at the read port within a cycle or two: a bad level flag or table base gives a second read at the wrong address, or a read where none belongs, and is caught before completion. A wrong decode or permission result shows up at the completion strobe as a wrong fault code or address, and a wrong accessed/dirty merge shows as a missing, extra or wrong write-back one cycle before completion. All sixteen low-bit codes are swept against every access kind, mode, U-bit and bypass value so that a single misdecoded code reaches the ports.

// File: rtl/sv32_walk_pkg.sv
// Shared constants and types for the Sv32 page table walker.
// Assumes 32-bit virtual addresses, 4 KiB pages and 32-bit entries.
package sv32_walk_pkg;
    localparam int XLEN        = 32;
    localparam int PG_OFS_W    = 12;
    localparam int VPN_IDX_W   = 10;
    localparam int PPN_W       = 20;
    localparam int PTE_PPN_LSB = 10;
    localparam int PTE_PPN_W   = XLEN - PTE_PPN_LSB;
    localparam int PPN_HI_W    = PTE_PPN_W - PPN_W;
    localparam int WORD_SHIFT  = 2;

    localparam int PTE_V = 0;
    localparam int PTE_R = 1;
    localparam int PTE_W = 2;
    localparam int PTE_X = 3;
    localparam int PTE_U = 4;
    localparam int PTE_A = 6;
    localparam int PTE_D = 7;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_PAGE   = 2'd1,
        FLT_ACCESS = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        PK_NEXT,
        PK_LEAF,
        PK_BAD
    } pte_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WB,
        ST_RESP
    } walk_st_e;
endpackage

// File: rtl/sv32_pte_classify.sv
// Sorts the low four entry bits (X,W,R,V) into pointer, leaf or invalid.
// Purely combinational; every one of the sixteen codes is listed or defaulted.
module sv32_pte_classify
    import sv32_walk_pkg::*;
(
    input  logic [3:0] xwrv,
    output pte_kind_e  kind
);
    // Explicit decode of each code; anything not listed is invalid.
    always_comb begin
        case (xwrv)
            4'b0001: kind = PK_NEXT;
            4'b0011,
            4'b0111,
            4'b1001,
            4'b1011,
            4'b1111: kind = PK_LEAF;
            default: kind = PK_BAD;
        endcase
    end
endmodule

// File: rtl/sv32_leaf_check.sv
// Checks a leaf entry: page number range, megapage alignment, access
// permission and privilege; builds the final page number and the entry
// with accessed/dirty merged in. Assumes the entry is already known a leaf.
module sv32_leaf_check
    import sv32_walk_pkg::*;
(
    input  logic [XLEN-1:0]      pte,
    input  logic                 at_top,
    input  logic [VPN_IDX_W-1:0] vpn_lo,
    input  logic [1:0]           acc,
    input  logic                 umode,
    input  logic                 bypass,
    output logic                 fault,
    output logic [PPN_W-1:0]     final_ppn,
    output logic [XLEN-1:0]      new_pte,
    output logic                 wb_needed
);
    logic [PTE_PPN_W-1:0] ppn;
    logic                 range_bad;
    logic                 misalign;
    logic                 perm_ok;
    logic                 priv_ok;
    logic [XLEN-1:0]      set_mask;

    assign ppn       = pte[XLEN-1:PTE_PPN_LSB];
    assign range_bad = |ppn[PTE_PPN_W-1:PPN_W];
    assign misalign  = at_top && (|ppn[VPN_IDX_W-1:0]);
    assign priv_ok   = bypass || (pte[PTE_U] == umode);

    // Pick the permission bit and the bits to merge for the access kind.
    always_comb begin
        set_mask        = '0;
        set_mask[PTE_A] = 1'b1;
        case (acc)
            ACC_FETCH: perm_ok = pte[PTE_X];
            ACC_STORE: begin
                perm_ok         = pte[PTE_W];
                set_mask[PTE_D] = 1'b1;
            end
            default:   perm_ok = pte[PTE_R];
        endcase
    end

    assign fault     = range_bad || misalign || !perm_ok || !priv_ok;
    assign final_ppn = at_top ? {ppn[PPN_W-1:VPN_IDX_W], vpn_lo} : ppn[PPN_W-1:0];
    assign new_pte   = pte | set_mask;
    assign wb_needed = (new_pte != pte);
endmodule

// File: rtl/sv32_pte_addr.sv
// Forms the byte address of a table entry from a table page number and
// a ten-bit index. Assumes entries are one word wide.
module sv32_pte_addr
    import sv32_walk_pkg::*;
(
    input  logic [PPN_W-1:0]     tbl_ppn,
    input  logic [VPN_IDX_W-1:0] idx,
    output logic [XLEN-1:0]      addr
);
    localparam int PAD_W = PG_OFS_W - VPN_IDX_W - WORD_SHIFT;

    // Page base plus index scaled to words.
    always_comb begin
        addr = {tbl_ppn, {PAD_W{1'b0}}, idx, {WORD_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/sv32_walker.sv
// Sv32 page table walker. Takes a request held stable until done, reads
// at most two entries, checks the leaf, optionally writes it back with
// accessed/dirty set, then pulses done with the address or fault.
// Assumes a single outstanding read and a write port that accepts at once.
module sv32_walker
    import sv32_walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [XLEN-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic             req_umode,
    input  logic             req_bypass,
    input  logic             req_xlate_en,
    input  logic [PPN_W-1:0] req_root_ppn,
    output logic             mem_rd_req,
    output logic [XLEN-1:0]  mem_rd_addr,
    input  logic             mem_rd_ack,
    input  logic [XLEN-1:0]  mem_rd_data,
    input  logic             mem_rd_err,
    output logic             mem_wr_en,
    output logic [XLEN-1:0]  mem_wr_addr,
    output logic [XLEN-1:0]  mem_wr_data,
    output logic             done,
    output logic [XLEN-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic [XLEN-1:0]  rsp_fault_vaddr
);
    walk_st_e             st_q;
    logic                 at_top_q;
    logic [XLEN-1:0]      rd_addr_q;
    logic [XLEN-1:0]      wb_data_q;
    logic [XLEN-1:0]      paddr_q;
    logic [XLEN-1:0]      fva_q;
    fault_e               fault_q;

    logic [VPN_IDX_W-1:0] vpn_hi;
    logic [VPN_IDX_W-1:0] vpn_lo;
    logic [XLEN-1:0]      root_addr;
    logic [XLEN-1:0]      next_addr;
    logic                 next_ppn_bad;
    pte_kind_e            kind;
    logic                 leaf_fault;
    logic [PPN_W-1:0]     leaf_ppn;
    logic [XLEN-1:0]      leaf_new;
    logic                 leaf_wb;

    assign vpn_hi       = req_vaddr[XLEN-1 -: VPN_IDX_W];
    assign vpn_lo       = req_vaddr[PG_OFS_W +: VPN_IDX_W];
    assign next_ppn_bad = |mem_rd_data[XLEN-1 -: PPN_HI_W];

    sv32_pte_addr u_root_addr (
        .tbl_ppn (req_root_ppn),
        .idx     (vpn_hi),
        .addr    (root_addr)
    );

    sv32_pte_addr u_next_addr (
        .tbl_ppn (mem_rd_data[PTE_PPN_LSB +: PPN_W]),
        .idx     (vpn_lo),
        .addr    (next_addr)
    );

    sv32_pte_classify u_classify (
        .xwrv (mem_rd_data[3:0]),
        .kind (kind)
    );

    sv32_leaf_check u_leaf (
        .pte       (mem_rd_data),
        .at_top    (at_top_q),
        .vpn_lo    (vpn_lo),
        .acc       (req_acc),
        .umode     (req_umode),
        .bypass    (req_bypass),
        .fault     (leaf_fault),
        .final_ppn (leaf_ppn),
        .new_pte   (leaf_new),
        .wb_needed (leaf_wb)
    );

    // Walk sequencer: start, consume each read, write back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            at_top_q  <= 1'b0;
            rd_addr_q <= '0;
            wb_data_q <= '0;
            paddr_q   <= '0;
            fva_q     <= '0;
            fault_q   <= FLT_NONE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        fault_q <= FLT_NONE;
                        fva_q   <= '0;
                        if (!req_xlate_en) begin
                            paddr_q <= req_vaddr;
                            st_q    <= ST_RESP;
                        end else begin
                            paddr_q   <= '0;
                            rd_addr_q <= root_addr;
                            at_top_q  <= 1'b1;
                            st_q      <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_rd_ack) begin
                        if (mem_rd_err) begin
                            fault_q <= FLT_ACCESS;
                            fva_q   <= req_vaddr;
                            st_q    <= ST_RESP;
                        end else begin
                            case (kind)
                                PK_NEXT: begin
                                    if (!at_top_q) begin
                                        fault_q <= FLT_PAGE;
                                        fva_q   <= req_vaddr;
                                        st_q    <= ST_RESP;
                                    end else if (next_ppn_bad) begin
                                        fault_q <= FLT_ACCESS;
                                        fva_q   <= req_vaddr;
                                        st_q    <= ST_RESP;
                                    end else begin
                                        rd_addr_q <= next_addr;
                                        at_top_q  <= 1'b0;
                                    end
                                end
                                PK_LEAF: begin
                                    if (leaf_fault) begin
                                        fault_q <= FLT_PAGE;
                                        fva_q   <= req_vaddr;
                                        st_q    <= ST_RESP;
                                    end else begin
                                        paddr_q <= {leaf_ppn, req_vaddr[PG_OFS_W-1:0]};
                                        if (leaf_wb) begin
                                            wb_data_q <= leaf_new;
                                            st_q      <= ST_WB;
                                        end else begin
                                            st_q <= ST_RESP;
                                        end
                                    end
                                end
                                default: begin
                                    fault_q <= FLT_PAGE;
                                    fva_q   <= req_vaddr;
                                    st_q    <= ST_RESP;
                                end
                            endcase
                        end
                    end
                end
                ST_WB:   st_q <= ST_RESP;
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the registered walk state.
    always_comb begin
        mem_rd_req      = (st_q == ST_READ);
        mem_rd_addr     = rd_addr_q;
        mem_wr_en       = (st_q == ST_WB);
        mem_wr_addr     = rd_addr_q;
        mem_wr_data     = wb_data_q;
        done            = (st_q == ST_RESP);
        rsp_paddr       = paddr_q;
        rsp_fault       = fault_q;
        rsp_fault_vaddr = fva_q;
    end
endmodule

// File: rtl/sv32_walker_chk.sv
// Port-level properties of the walker, attached by bind.
// Assumes the requester holds its request until done.
module sv32_walker_chk
    import sv32_walk_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] req_vaddr,
    input logic            mem_rd_req,
    input logic [XLEN-1:0] mem_rd_addr,
    input logic            mem_rd_ack,
    input logic            mem_wr_en,
    input logic [XLEN-1:0] mem_wr_data,
    input logic            done,
    input logic [XLEN-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault,
    input logic [XLEN-1:0] rsp_fault_vaddr
);
    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00)); // R1

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R10

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_en)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_WB_HAS_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wr_data[PTE_A]); // R7

    AST_WB_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (done && rsp_fault == 2'd0)); // R7

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_fault == 2'd0) |-> (rsp_paddr[PG_OFS_W-1:0] == req_vaddr[PG_OFS_W-1:0])); // R9

    AST_FAULT_VADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_fault != 2'd0) |-> (rsp_fault_vaddr == req_vaddr)); // R8
endmodule

bind sv32_walker sv32_walker_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_vaddr       (req_vaddr),
    .mem_rd_req      (mem_rd_req),
    .mem_rd_addr     (mem_rd_addr),
    .mem_rd_ack      (mem_rd_ack),
    .mem_wr_en       (mem_wr_en),
    .mem_wr_data     (mem_wr_data),
    .done            (done),
    .rsp_paddr       (rsp_paddr),
    .rsp_fault       (rsp_fault),
    .rsp_fault_vaddr (rsp_fault_vaddr)
);

// File: tb/sv32_walker_tb.sv
`timescale 1ns/1ps
// Bench for the walker: a behavioural reference computes each walk's
// reads, write-back and answer from a sparse memory model.
module sv32_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_umode = 1'b0;
    logic        req_bypass = 1'b0;
    logic        req_xlate_en = 1'b0;
    logic [19:0] req_root_ppn = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_err = 1'b0;
    logic        mem_wr_en;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        done;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_fault_vaddr;

    always #2.5 clk = ~clk;

    sv32_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_umode(req_umode), .req_bypass(req_bypass),
        .req_xlate_en(req_xlate_en), .req_root_ppn(req_root_ppn),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .done(done),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_fault_vaddr(rsp_fault_vaddr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    bit prev_done = 0;

    logic [31:0] mem [logic [31:0]];
    bit          errs [logic [31:0]];
    logic [31:0] obs_rd [$];
    logic [31:0] obs_wa [$];
    logic [31:0] obs_wd [$];
    logic [31:0] exp_rd [$];
    logic [1:0]  exp_fault;
    logic [31:0] exp_pa;
    bit          exp_wr;
    logic [31:0] exp_wa, exp_wd;

    localparam logic [19:0] ROOT = 20'h00010;
    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FA = 8'h40, FD = 8'h80;

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    function automatic logic [31:0] l1a(input logic [31:0] va);
        return {ROOT, 12'h0} + {20'h0, va[31:22], 2'b00};
    endfunction

    // Reference walk from the requirements, on the current memory image.
    function automatic void ref_walk(input logic [31:0] va, input logic [1:0] acc,
                                     input bit um, input bit byp, input bit en,
                                     input logic [19:0] root);
        logic [31:0] base, a, p, nw;
        logic [21:0] ppn;
        logic [19:0] fin;
        bit need;
        exp_rd.delete();
        exp_wr = 0; exp_wa = 0; exp_wd = 0;
        exp_fault = 2'd0;
        exp_pa = va;
        if (!en) return;
        exp_pa = 0;
        base = {root, 12'h0};
        for (int lvl = 1; lvl >= 0; lvl--) begin
            a = base + ((lvl == 1) ? {20'h0, va[31:22], 2'b00} : {20'h0, va[21:12], 2'b00});
            exp_rd.push_back(a);
            if (errs.exists(a)) begin exp_fault = 2'd2; return; end
            p = mrd(a);
            if (p[3:0] == 4'b0001) begin
                if (lvl == 0) begin exp_fault = 2'd1; return; end
                if (p[31:30] != 2'b00) begin exp_fault = 2'd2; return; end
                base = {p[29:10], 12'h0};
                continue;
            end
            if (!(p[3:0] inside {4'h3, 4'h7, 4'h9, 4'hB, 4'hF})) begin exp_fault = 2'd1; return; end
            ppn = p[31:10];
            if (ppn[21:20] != 2'b00) begin exp_fault = 2'd1; return; end
            if (lvl == 1 && ppn[9:0] != 10'h0) begin exp_fault = 2'd1; return; end
            need = (acc == 2'd0) ? p[3] : (acc == 2'd2) ? p[2] : p[1];
            if (!need) begin exp_fault = 2'd1; return; end
            if (!byp && (p[4] != um)) begin exp_fault = 2'd1; return; end
            fin = ppn[19:0] + ((lvl == 1) ? {10'h0, va[21:12]} : 20'h0);
            exp_pa = {fin, va[11:0]};
            nw = p | ((acc == 2'd2) ? 32'hC0 : 32'h40);
            if (nw != p) begin exp_wr = 1; exp_wa = a; exp_wd = nw; end
            return;
        end
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] expv);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, expv);
        end
    endtask

    // Memory model: one-cycle acknowledge, error set, applies write-backs.
    always @(negedge clk) begin
        if (mem_rd_req && !mem_rd_ack) begin
            mem_rd_ack  <= 1'b1;
            mem_rd_data <= mrd(mem_rd_addr);
            mem_rd_err  <= errs.exists(mem_rd_addr);
            obs_rd.push_back(mem_rd_addr);
        end else begin
            mem_rd_ack <= 1'b0;
            mem_rd_err <= 1'b0;
        end
        if (mem_wr_en) begin
            obs_wa.push_back(mem_wr_addr);
            obs_wd.push_back(mem_wr_data);
            mem[mem_wr_addr] = mem_wr_data;
        end
    end

    // Per-clock comparison of port-level invariants.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10", "read and write together", {31'h0, mem_rd_req && mem_wr_en}, 32'h0);
            chk("R10", "done longer than one cycle", {31'h0, prev_done && done}, 32'h0);
            prev_done = done;
        end
    end

    // One walk: reference first, then drive, wait for done, compare.
    task automatic run_one(input string tag, input logic [31:0] va, input logic [1:0] acc,
                           input bit um, input bit byp, input bit en);
        int cyc;
        ref_walk(va, acc, um, byp, en, ROOT);
        obs_rd.delete(); obs_wa.delete(); obs_wd.delete();
        req_vaddr = va; req_acc = acc; req_umode = um; req_bypass = byp;
        req_xlate_en = en; req_root_ppn = ROOT; req_valid = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!done && cyc < 64);
        chk("R10", "done seen", {31'h0, done}, 32'h1);
        if (done) begin
            chk(tag, "fault code", {30'h0, rsp_fault}, {30'h0, exp_fault});
            if (exp_fault == 2'd0) chk(tag, "paddr", rsp_paddr, exp_pa);
            else chk("R8", "fault vaddr", rsp_fault_vaddr, va);
            chk("R1", "read count", obs_rd.size(), exp_rd.size());
            for (int i = 0; i < exp_rd.size() && i < obs_rd.size(); i++)
                chk("R1", "read address", obs_rd[i], exp_rd[i]);
            chk("R7", "write count", obs_wa.size(), exp_wr ? 1 : 0);
            if (exp_wr && obs_wa.size() == 1) begin
                chk("R7", "write address", obs_wa[0], exp_wa);
                chk("R7", "write data", obs_wd[0], exp_wd);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_mem();
        mem.delete();
        errs.delete();
    endtask

    localparam logic [31:0] VA = 32'h4080_3ABC;
    localparam logic [31:0] L0A = 32'h0002_000C;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "idle read", {31'h0, mem_rd_req}, 32'h0);
        chk("R11", "idle write", {31'h0, mem_wr_en}, 32'h0);
        chk("R11", "idle done", {31'h0, done}, 32'h0);

        // R9 translation off
        run_one("R9", 32'hDEAD_B123, 2'd1, 1'b0, 1'b0, 1'b0);

        // R1 R9 two-level load, accessed already set, no write
        clear_mem();
        mem[l1a(VA)] = mk(22'h00020, FV);
        mem[L0A] = mk(22'h12345, FV | FR | FA);
        run_one("R9", VA, 2'd1, 1'b0, 1'b0, 1'b1);

        // R7 store sets A and D
        mem[L0A] = mk(22'h12345, FV | FR | FW);
        run_one("R7", VA, 2'd2, 1'b0, 1'b0, 1'b1);
        // R7 same store again: no change, no write
        run_one("R7", VA, 2'd2, 1'b0, 1'b0, 1'b1);

        // R5 R6 user fetch on executable user page
        mem[L0A] = mk(22'h0ABCD, FV | FR | FX | FU);
        run_one("R5", VA, 2'd0, 1'b1, 1'b0, 1'b1);
        // R5 fetch on non-executable page
        mem[L0A] = mk(22'h0ABCD, FV | FR | FW | FA | FD);
        run_one("R5", VA, 2'd0, 1'b0, 1'b0, 1'b1);
        // R5 load on execute-only page
        mem[L0A] = mk(22'h0ABCD, FV | FX | FA);
        run_one("R5", VA, 2'd1, 1'b0, 1'b0, 1'b1);

        // R6 user page from supervisor, without and with bypass
        mem[L0A] = mk(22'h0ABCD, FV | FR | FU | FA);
        run_one("R6", VA, 2'd1, 1'b0, 1'b0, 1'b1);
        run_one("R6", VA, 2'd1, 1'b0, 1'b1, 1'b1);
        // R6 supervisor page from user mode
        mem[L0A] = mk(22'h0ABCD, FV | FR | FA);
        run_one("R6", VA, 2'd1, 1'b1, 1'b0, 1'b1);

        // R3 aligned and misaligned megapage
        clear_mem();
        mem[l1a(VA)] = mk(22'h00C00, FV | FR | FW | FA | FD);
        run_one("R3", VA, 2'd2, 1'b0, 1'b0, 1'b1);
        mem[l1a(VA)] = mk(22'h00C01, FV | FR | FW | FA | FD);
        run_one("R3", VA, 2'd1, 1'b0, 1'b0, 1'b1);

        // R4 leaf page number out of range; pointer out of range
        clear_mem();
        mem[l1a(VA)] = mk(22'h00020, FV);
        mem[L0A] = mk(22'h100345, FV | FR | FA);
        run_one("R4", VA, 2'd1, 1'b0, 1'b0, 1'b1);
        mem[l1a(VA)] = mk(22'h200020, FV);
        run_one("R4", VA, 2'd1, 1'b0, 1'b0, 1'b1);

        // R8 read error at second level, then at top level
        clear_mem();
        mem[l1a(VA)] = mk(22'h00020, FV);
        errs[L0A] = 1'b1;
        run_one("R8", VA, 2'd1, 1'b0, 1'b0, 1'b1);
        errs[l1a(VA)] = 1'b1;
        run_one("R8", VA, 2'd0, 1'b1, 1'b0, 1'b1);

        // R2 pointer at second level; invalid top-level entry
        clear_mem();
        mem[l1a(VA)] = mk(22'h00020, FV);
        mem[L0A] = mk(22'h00030, FV);
        run_one("R2", VA, 2'd1, 1'b0, 1'b0, 1'b1);
        mem[l1a(VA)] = mk(22'h00020, FX | FW | FR);
        run_one("R2", VA, 2'd1, 1'b0, 1'b0, 1'b1);

        // R2 sweep of every low code with every access, mode, U bit and bypass
        for (int code = 0; code < 16; code++)
            for (int acc = 0; acc < 3; acc++)
                for (int um = 0; um < 2; um++)
                    for (int ub = 0; ub < 2; ub++)
                        for (int byp = 0; byp < 2; byp++) begin
                            clear_mem();
                            mem[l1a(VA)] = mk(22'h00C00, (ub != 0 ? FU : 8'h0) | 8'(code));
                            mem[32'h00C0_000C] = mk(22'h00ABC, FV | FR | FW | FX | FA | (ub != 0 ? FU : 8'h0));
                            run_one("R2", VA, 2'(acc), um[0], byp[0], 1'b1);
                        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule